// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block merges sixteen external interrupt request lines into one interrupt output for a host processor. Each line is sampled on every clock. While a line is high and its enable bit is set, the matching bit of a sticky pending register is latched. The latched bit stays set after the line drops, until software overwrites it. The single output is high whenever at least one bit is both pending and enabled.

Software reaches the block through a small 32-bit register port. A write takes one cycle and a read is combinational. The enable register and the pending register are readable and writable. A third register shows the sampled line levels and is read-only. A write replaces the whole target register, not only the bits that are set. Every value written passes through one fixed writable-bit mask. That mask keeps bits 0-7, 9-11 and 13-19 and forces all other bits to zero.

Top module: `irq_aggregator`

## Requirements
- R1: The level register captures `irq_in` on every clock edge outside reset. A read at offset 0xE8 returns it in bits 15:0, with zeros above.
- R2: When `irq_in[i]` is high and enable bit i is set at a clock edge, pending bit i reads 1 from the next cycle on.
- R3: A line that is high while its enable bit is clear does not set its pending bit.
- R4: A pending bit stays set after its line returns low. Only a write to the pending register can clear it.
- R5: A write at offset 0xD0 replaces the pending register with the write data ANDed with 0x000FEEFF. Bits 8, 12 and 20-31 therefore always read 0.
- R6: A write at offset 0xC0 stores the write data ANDed with 0x000FEEFF in the enable register. The enable register is unchanged when no write targets it.
- R7: `irq_out` is high exactly when the bitwise AND of the pending and enable registers is nonzero. It reflects a register write from the cycle after that write.
- R8: If a write to the pending register and a hardware set of the same bit happen in the same cycle, the bit ends up set.
- R9: A clock edge with `rst_n` low clears the enable, pending and level registers, so `irq_out` is low from the next cycle.
- R10: Reads have no side effects. A read of any offset other than 0xC0, 0xD0 or 0xE8 returns 0. A write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 16 | External interrupt request levels, one per line |
| reg_addr | input | 8 | Byte offset for a register read or write |
| reg_we | input | 1 | Write strobe; data is taken on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined interrupt, high while any enabled bit is pending |

## Verification
The bench holds a request line high while software writes zero to the pending register in the same cycle. A design that lets the write win would drop that request. It also raises a line while its enable bit is clear and checks that no pending bit appears, which catches a design that latches raw levels and only masks the output. It writes all-ones to both masked registers and checks that bits 8 and 12 come back as zero. It drops a line after its bit has been latched and checks that the bit is still set, which exposes a level-following pending register. A long stretch of random traffic is compared on every cycle against a behavioural model, which shows up an output that lags or leads the registers.

// File: rtl/irq_agg_pkg.sv
// Package: shared types and constants for the interrupt aggregator.
// Assumes a 32-bit register port with byte offsets that fit in 8 bits.
package irq_agg_pkg;

    // Which register a port access targets.
    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_PENDING = 2'd2,
        SEL_LEVEL   = 2'd3
    } reg_sel_e;

    // Bits that software may set in the enable and pending registers.
    localparam logic [31:0] WRITABLE_MASK = 32'h000F_EEFF;

endpackage

// File: rtl/irq_addr_decode.sv
// Module: irq_addr_decode
// Maps a byte offset onto one of the block's registers. The decode is
// purely combinational and is shared by the read path and the write path.
// Assumes that the three offsets are distinct.
module irq_addr_decode
    import irq_agg_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] OFS_ENABLE  = 8'hC0,
    parameter logic [ADDR_W-1:0] OFS_PENDING = 8'hD0,
    parameter logic [ADDR_W-1:0] OFS_LEVEL   = 8'hE8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Compare the offset against each register and pick one.
    always_comb begin
        if (addr == OFS_ENABLE)       sel = SEL_ENABLE;
        else if (addr == OFS_PENDING) sel = SEL_PENDING;
        else if (addr == OFS_LEVEL)   sel = SEL_LEVEL;
        else                          sel = SEL_NONE;
    end

endmodule

// File: rtl/irq_level_track.sv
// Module: irq_level_track
// Samples the external request lines once per clock into the level
// register. Assumes the lines are already synchronous to clk.
module irq_level_track #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] level_q
);

    // Capture the present line levels, or clear them during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= lines_in;
    end

    // R1: the level register follows the lines one cycle later.
    a_r1_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> level_q == $past(lines_in));

endmodule

// File: rtl/irq_enable_reg.sv
// Module: irq_enable_reg
// Holds the per-bit enable (mask) register. A write replaces the whole
// register with masked data. Assumes wr_en is already qualified by the
// address decode.
module irq_enable_reg #(
    parameter int          DATA_W = 32,
    parameter logic [DATA_W-1:0] WMASK = 32'h000F_EEFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q
);

    // Load masked write data, or hold the value.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata & WMASK;
    end

    // R6: a write leaves exactly the masked data in the register.
    a_r6_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> en_q == ($past(wdata) & WMASK));

    // R6: the register holds its value when no write targets it.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));

endmodule

// File: rtl/irq_pending_bank.sv
// Module: irq_pending_bank
// Sticky pending register. A line bit is latched while the line is high
// and enabled. A software write replaces the register with masked data.
// A hardware set in the same cycle still wins. Bits above NUM_LINES can
// only be changed by software. Assumes NUM_LINES <= DATA_W.
module irq_pending_bank #(
    parameter int          NUM_LINES = 16,
    parameter int          DATA_W    = 32,
    parameter logic [DATA_W-1:0] WMASK = 32'h000F_EEFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_in,
    input  logic [NUM_LINES-1:0] en_lines,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    pend_q
);

    logic [DATA_W-1:0] hw_set;
    logic [DATA_W-1:0] base;

    // Widen the enabled requests to the register width; bits above the
    // lines receive no hardware set.
    for (genvar b = 0; b < DATA_W; b++) begin : g_set
        if (b < NUM_LINES) begin : g_line
            assign hw_set[b] = lines_in[b] & en_lines[b];
        end else begin : g_soft
            assign hw_set[b] = 1'b0;
        end
    end

    // Take the software value when written, else keep the current value.
    always_comb begin
        base = wr_en ? wdata : pend_q;
    end

    // Merge the sticky hardware sets and apply the writable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (base | hw_set) & WMASK;
    end

    // R2 / R8: an enabled high line is pending in the next cycle, even
    // when a write lands in the same cycle.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hw_set) & WMASK & ~pend_q) == '0));

    // R4: without a write, no pending bit is ever cleared.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (($past(pend_q) & ~pend_q) == '0));

    // R3: without a write, a bit only rises through an enabled high line.
    a_r3_no_unenabled_set: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((pend_q & ~$past(pend_q) & ~$past(hw_set)) == '0));

endmodule

// File: rtl/irq_aggregator.sv
// Module: irq_aggregator (top)
// Merges NUM_LINES request lines into one interrupt output. It holds a
// level register, an enable register and a sticky pending register, all
// reached through a one-cycle-write, combinational-read register port.
// Assumes a synchronous active-low reset and lines synchronous to clk.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_out
);

    localparam logic [DATA_W-1:0] WMASK  = DATA_W'(WRITABLE_MASK);
    localparam int                PAD_W  = DATA_W - NUM_LINES;

    reg_sel_e             sel;
    logic                 wr_enable;
    logic                 wr_pending;
    logic [NUM_LINES-1:0] level_q;
    logic [DATA_W-1:0]    en_q;
    logic [DATA_W-1:0]    pend_q;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (reg_addr),
        .sel  (sel)
    );

    // Qualify the write strobe per register.
    always_comb begin
        wr_enable  = reg_we && (sel == SEL_ENABLE);
        wr_pending = reg_we && (sel == SEL_PENDING);
    end

    irq_level_track #(.NUM_LINES(NUM_LINES)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (irq_in),
        .level_q  (level_q)
    );

    irq_enable_reg #(.DATA_W(DATA_W), .WMASK(WMASK)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_enable),
        .wdata (reg_wdata),
        .en_q  (en_q)
    );

    irq_pending_bank #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .WMASK(WMASK)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (irq_in),
        .en_lines (en_q[NUM_LINES-1:0]),
        .wr_en    (wr_pending),
        .wdata    (reg_wdata),
        .pend_q   (pend_q)
    );

    // Return the selected register; unmapped offsets read zero.
    always_comb begin
        case (sel)
            SEL_ENABLE:  reg_rdata = en_q;
            SEL_PENDING: reg_rdata = pend_q;
            SEL_LEVEL:   reg_rdata = {{PAD_W{1'b0}}, level_q};
            default:     reg_rdata = '0;
        endcase
    end

    // Raise the combined interrupt while any enabled bit is pending.
    always_comb begin
        irq_out = |(pend_q & en_q);
    end

    // R9: a reset edge leaves the output low in the following cycle.
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

    // R10: a write to an unmapped offset changes neither masked register.
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel == SEL_NONE && (irq_in & en_q[NUM_LINES-1:0]) == '0)
        |=> $stable(en_q) && $stable(pend_q));

endmodule

// File: tb/tb_irq_aggregator.sv
// Bench for irq_aggregator: a behavioural model updated on each rising
// edge and compared with the outputs before every edge.
module tb_irq_aggregator;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MSK = 32'h000F_EEFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_in;
    logic [7:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model state
    logic [15:0] m_level = '0;
    logic [31:0] m_en    = '0;
    logic [31:0] m_pend  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'hC0:   return m_en;
            8'hD0:   return m_pend;
            8'hE8:   return {16'h0, m_level};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'hC0:   return "R6 enable read";
            8'hD0:   return "R5 pending read";
            8'hE8:   return "R1 level read";
            default: return "R10 unmapped read";
        endcase
    endfunction

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input string ctx, input logic rst, input logic [15:0] irq,
                        input logic we, input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] hw;
        rst_n = rst; irq_in = irq; reg_we = we; reg_addr = a; reg_wdata = wd;
        #1;
        check({ctx, " / ", read_tag(a)}, reg_rdata, model_read(a));
        check({ctx, " / R7 irq_out"}, {31'h0, irq_out}, {31'h0, |(m_pend & m_en)});
        @(posedge clk);
        if (!rst) begin
            m_level = '0; m_en = '0; m_pend = '0;
        end else begin
            hw = {16'h0, irq & m_en[15:0]};
            m_level = irq;
            m_pend  = (((we && a == 8'hD0) ? wd : m_pend) | hw) & MSK;
            if (we && a == 8'hC0) m_en = wd & MSK;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        if (!done) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        @(negedge clk);
        // R9: reset state
        step("R9 reset", 1'b0, 16'hFFFF, 1'b1, 8'hC0, 32'hFFFF_FFFF);
        step("R9 reset", 1'b0, 16'hFFFF, 1'b0, 8'hC0, 32'h0);
        step("R9 reset", 1'b1, 16'h0000, 1'b0, 8'hD0, 32'h0);
        // R6: enable all writable bits, read back masked value
        step("R6 write", 1'b1, 16'h0, 1'b1, 8'hC0, 32'hFFFF_FFFF);
        step("R6 readback", 1'b1, 16'h0, 1'b0, 8'hC0, 32'h0);
        // R2: enabled line latches
        step("R2 raise", 1'b1, 16'h0001, 1'b0, 8'hD0, 32'h0);
        // R4: line drops, bit stays
        step("R4 drop", 1'b1, 16'h0000, 1'b0, 8'hD0, 32'h0);
        step("R4 hold", 1'b1, 16'h0000, 1'b0, 8'hD0, 32'h0);
        // R7: disable all, output falls while pending stays
        step("R7 disable", 1'b1, 16'h0, 1'b1, 8'hC0, 32'h0);
        step("R7 after", 1'b1, 16'h0, 1'b0, 8'hD0, 32'h0);
        // R3: high line with enable clear
        step("R3 unenabled", 1'b1, 16'h0102, 1'b0, 8'hD0, 32'h0);
        step("R3 check", 1'b1, 16'h0000, 1'b0, 8'hD0, 32'h0);
        // R5: overwrite pending with all ones, bits 8,12,20+ stay zero
        step("R5 write", 1'b1, 16'h0, 1'b1, 8'hD0, 32'hFFFF_FFFF);
        step("R5 readback", 1'b1, 16'h0, 1'b0, 8'hD0, 32'h0);
        step("R5 clear", 1'b1, 16'h0, 1'b1, 8'hD0, 32'h0);
        // R8: hardware set beats a same-cycle clearing write
        step("R8 enable", 1'b1, 16'h0, 1'b1, 8'hC0, 32'h0000_0004);
        step("R8 collide", 1'b1, 16'h0004, 1'b1, 8'hD0, 32'h0);
        step("R8 result", 1'b1, 16'h0000, 1'b0, 8'hD0, 32'h0);
        // R1: level register
        step("R1 drive", 1'b1, 16'hA5A5, 1'b0, 8'hE8, 32'h0);
        step("R1 read", 1'b1, 16'h5A5A, 1'b0, 8'hE8, 32'h0);
        // R10: unmapped write and read, then masked registers unchanged
        step("R10 write", 1'b1, 16'h0, 1'b1, 8'h40, 32'hFFFF_FFFF);
        step("R10 read", 1'b1, 16'h0, 1'b0, 8'h40, 32'h0);
        step("R10 enable", 1'b1, 16'h0, 1'b0, 8'hC0, 32'h0);
        step("R10 pending", 1'b1, 16'h0, 1'b0, 8'hD0, 32'h0);
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [1:0] pick = 2'($urandom_range(0, 3));
            a = (pick == 2'd0) ? 8'hC0 : (pick == 2'd1) ? 8'hD0 :
                (pick == 2'd2) ? 8'hE8 : 8'($urandom);
            step("R7 random", 1'b1, 16'($urandom) & 16'($urandom),
                 ($urandom_range(0, 3) == 0), a, $urandom);
        end
        // R9: reset from a busy state
        step("R9 prep", 1'b1, 16'h0, 1'b1, 8'hC0, 32'hFFFF_FFFF);
        step("R9 prep", 1'b1, 16'h00FF, 1'b0, 8'hD0, 32'h0);
        step("R9 midrun", 1'b0, 16'h00FF, 1'b0, 8'hD0, 32'h0);
        step("R9 cleared", 1'b1, 16'h0000, 1'b0, 8'hD0, 32'h0);
        step("R9 cleared", 1'b1, 16'h0000, 1'b0, 8'hC0, 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule